// File: doc/BRIEF.md
# Staged Clock Reprogramming Sequencer

This block changes a clock-control register in two steps, so that the clock logic downstream never sees the source and the divider change together. A host request carries two words. The first is an intermediate word in which only the source-select bits differ from the current setting. The second is the complete word, which also carries the new divider and shift values. The block writes the intermediate word first and then waits one full vertical-sync period for the clock logic to settle. It then writes the complete word and waits one more vertical-sync period. Only after that second wait does it report that the request is finished.

Each settle wait has two phases. The first phase waits for the synchronised vsync level to go low. The second phase waits for it to go high again. Every cycle spent in a phase counts as one poll. If a phase reaches its poll limit, the sequence moves on as if the awaited level had arrived, and a sticky flag records that a timeout happened. A request is ignored while a sequence is running. The vsync status input is asynchronous to the clock and passes through a two-stage synchroniser before the sequencer uses it.

Top module: `clk_stage_seq`

## Requirements
- R1: For each accepted request there are exactly two write strobes, and each strobe lasts one cycle. The first strobe carries the intermediate word and the second carries the final word.
- R2: A request is accepted when `req_valid` is high and `busy` is low. The first write strobe appears in the cycle after acceptance.
- R3: Each settle wait first waits for synchronised vsync to be low and then for it to be high. With the two-stage synchroniser, the second write, or `done`, appears 3 cycles after the rising vsync edge that ends the wait. That rising edge must come after the preceding write.
- R4: A wait phase that never sees its level ends after `TIMEOUT_POLLS` cycles. With vsync held constant, the second write comes `TIMEOUT_POLLS`+2 cycles after the first, and `done` comes `TIMEOUT_POLLS`+2 cycles after the second write.
- R5: `busy` is high from the first write until the sequence ends. `done` is a single-cycle pulse that appears with `busy` already low, and no write strobe occurs while `busy` is low.
- R6: A request presented while `busy` is high has no effect. No extra write occurs, and the words written are those of the accepted request.
- R7: `timeout_seen` goes high when any wait phase of a sequence times out. It keeps its value after `done` and is cleared when the next request is accepted.
- R8: During reset, `reg_wr_en`, `busy`, `done` and `timeout_seen` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_mid_word | input | DATA_W | Intermediate word with the source-select bits changed |
| req_final_word | input | DATA_W | Complete word with divider and shift |
| vsync_raw | input | 1 | Asynchronous vsync status level, active high |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_data | output | DATA_W | Register write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timeout_seen | output | 1 | A wait phase timed out in the current or last sequence |

## Verification
Some properties are checked on every cycle: write strobes are never back to back and never occur outside `busy`, `done` is one cycle long and falls while idle, the captured words stay fixed while a request is refused, and a timer expiry always clears the poll count. Other behaviour depends on real vsync waveforms, so only the bench scenarios can show it. These are the 3-cycle distance from a vsync rise to the following write or `done`, the exact timeout spacing when vsync is held high or held low, the ordering of the intermediate and final data, and the clearing of the timeout flag by the next request.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_MID,
    ST_W1_LO,
    ST_W1_HI,
    ST_WR_FIN,
    ST_W2_LO,
    ST_W2_HI
  } seq_state_e;
endpackage

// File: rtl/clkseq_sync2.sv
module clkseq_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic ff1_q;
  logic ff2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= d;
      ff2_q <= ff1_q;
    end
  end

  assign q = ff2_q;
endmodule

// File: rtl/clkseq_poll_timer.sv
module clkseq_poll_timer #(
  parameter int LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign expired = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (!expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: the sequencer must leave a phase when the poll limit is hit
  p_expire_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> clr);
endmodule

// File: rtl/clkseq_fsm.sv
module clkseq_fsm
  import clkseq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] req_mid_word,
  input  logic [DATA_W-1:0] req_final_word,
  input  logic              vs_sync,
  input  logic              expired,
  output logic              timer_clr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic              busy,
  output logic              done,
  output logic              timeout_seen
);
  seq_state_e        state_q, state_d;
  logic [DATA_W-1:0] mid_q, fin_q;
  logic              done_q, done_d;
  logic              to_q, to_d;
  logic              accept, in_wait, want_low, level_met, advance;

  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign want_low  = (state_q == ST_W1_LO) || (state_q == ST_W2_LO);
  assign in_wait   = want_low || (state_q == ST_W1_HI) || (state_q == ST_W2_HI);
  assign level_met = want_low ? !vs_sync : vs_sync;
  assign advance   = in_wait && (level_met || expired);
  assign timer_clr = !in_wait || advance;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid) state_d = ST_WR_MID;
      ST_WR_MID: state_d = ST_W1_LO;
      ST_W1_LO:  if (advance) state_d = ST_W1_HI;
      ST_W1_HI:  if (advance) state_d = ST_WR_FIN;
      ST_WR_FIN: state_d = ST_W2_LO;
      ST_W2_LO:  if (advance) state_d = ST_W2_HI;
      ST_W2_HI:  if (advance) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    done_d = (state_q == ST_W2_HI) && advance;
    to_d   = to_q;
    if (accept)                             to_d = 1'b0;
    else if (in_wait && !level_met && expired) to_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      to_q    <= to_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q <= '0;
      fin_q <= '0;
    end else if (accept) begin
      mid_q <= req_mid_word;
      fin_q <= req_final_word;
    end
  end

  assign reg_wr_en    = (state_q == ST_WR_MID) || (state_q == ST_WR_FIN);
  assign reg_wr_data  = (state_q == ST_WR_MID) ? mid_q : fin_q;
  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign timeout_seen = to_q;

  p_wr_spaced_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);
  p_wr_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> busy);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> ($stable(mid_q) && $stable(fin_q)));
  p_to_in_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_seen) |-> $past(busy));
endmodule

// File: rtl/clk_stage_seq.sv
module clk_stage_seq #(
  parameter int DATA_W        = 32,
  parameter int TIMEOUT_POLLS = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] req_mid_word,
  input  logic [DATA_W-1:0] req_final_word,
  input  logic              vsync_raw,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic              busy,
  output logic              done,
  output logic              timeout_seen
);
  logic vs_sync;
  logic timer_clr;
  logic expired;

  clkseq_sync2 u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (vsync_raw),
    .q     (vs_sync)
  );

  clkseq_poll_timer #(.LIMIT(TIMEOUT_POLLS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (timer_clr),
    .expired (expired)
  );

  clkseq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_mid_word   (req_mid_word),
    .req_final_word (req_final_word),
    .vs_sync        (vs_sync),
    .expired        (expired),
    .timer_clr      (timer_clr),
    .reg_wr_en      (reg_wr_en),
    .reg_wr_data    (reg_wr_data),
    .busy           (busy),
    .done           (done),
    .timeout_seen   (timeout_seen)
  );
endmodule

// File: tb/clk_stage_seq_tb_top.sv
module clk_stage_seq_tb_top;
  localparam int DW = 32;
  localparam int TO = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [DW-1:0] req_mid_word = '0;
  logic [DW-1:0] req_final_word = '0;
  logic          vsync_raw = 1'b0;
  logic          reg_wr_en, busy, done, timeout_seen;
  logic [DW-1:0] reg_wr_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int vmode = 0;
  int vs_left = 8;
  int last_rise = -100;
  int prev_event = 0;
  int acc_cyc = 0;
  int seq_wr = 0;
  logic          exp_to = 1'b0;
  logic [DW-1:0] exp_mid = '0;
  logic [DW-1:0] exp_fin = '0;

  clk_stage_seq #(.DATA_W(DW), .TIMEOUT_POLLS(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_mid_word(req_mid_word), .req_final_word(req_final_word),
    .vsync_raw(vsync_raw), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .busy(busy), .done(done), .timeout_seen(timeout_seen));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int gap_expected();
    return TO + 2;
  endfunction

  task automatic event_timing(input string req);
    if (vmode == 0) begin
      chk(cyc - last_rise == 3, req, cyc - last_rise, 3);
      chk(last_rise > prev_event - 2, req, last_rise, prev_event - 1);
    end else begin
      chk(cyc - prev_event == gap_expected(), "R4", cyc - prev_event, gap_expected());
    end
  endtask

  // monitor first, then drive vsync, all at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr_en) begin
        if (seq_wr == 0) begin
          chk(reg_wr_data == exp_mid, "R1", reg_wr_data, exp_mid);
          chk(cyc == acc_cyc + 1, "R2", cyc, acc_cyc + 1);
          chk(timeout_seen == 1'b0, "R7", timeout_seen, 0);
        end else if (seq_wr == 1) begin
          chk(reg_wr_data == exp_fin, "R1", reg_wr_data, exp_fin);
          event_timing("R3");
        end else begin
          chk(1'b0, "R6", seq_wr + 1, 2);
        end
        seq_wr++;
        prev_event = cyc;
      end
      if (done) begin
        chk(seq_wr == 2, "R1", seq_wr, 2);
        chk(busy == 1'b0, "R5", busy, 0);
        chk(timeout_seen == exp_to, "R7", timeout_seen, exp_to);
        event_timing("R3");
        seq_wr = 0;
      end else if (seq_wr > 0) begin
        chk(busy == 1'b1, "R5", busy, 1);
      end
    end
    case (vmode)
      1: vsync_raw <= 1'b1;
      2: vsync_raw <= 1'b0;
      default: begin
        if (vs_left == 0) begin
          if (!vsync_raw) begin
            last_rise = cyc;
            vs_left = 6 + int'($urandom % 5);
          end else begin
            vs_left = 6 + int'($urandom % 25);
          end
          vsync_raw <= ~vsync_raw;
        end else begin
          vs_left--;
        end
      end
    endcase
  end

  task automatic run_seq(input logic [DW-1:0] m, input logic [DW-1:0] f, input logic to_exp);
    @(negedge clk);
    exp_mid = m; exp_fin = f; exp_to = to_exp;
    req_mid_word = m; req_final_word = f; req_valid = 1'b1;
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    wait (seq_wr == 1);
    @(negedge clk);
    // R6: stray request while busy
    req_mid_word = ~m; req_final_word = ~f; req_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge done);
    repeat (4) @(negedge clk);
    chk(reg_wr_en == 1'b0, "R6", reg_wr_en, 0);
    chk(timeout_seen == to_exp, "R7", timeout_seen, to_exp);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(reg_wr_en == 0 && busy == 0 && done == 0 && timeout_seen == 0, "R8",
        {reg_wr_en, busy, done, timeout_seen}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 6; i++) run_seq($urandom, $urandom, 1'b0);
    vmode = 1;
    repeat (6) @(negedge clk);
    run_seq(32'hA5A5_0001, 32'h5A5A_0F02, 1'b1);
    vmode = 2;
    repeat (6) @(negedge clk);
    run_seq(32'h0000_00FF, 32'hFF00_0000, 1'b1);
    vmode = 0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 3; i++) run_seq($urandom, $urandom, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule